// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block keeps the sharing record for every memory block homed at one node of a distributed shared-memory machine. Each record holds one presence bit per node and a dirty flag. The block also holds the home copy of each block's data word. Requesting nodes send read-miss and write-miss messages. The directory answers in one of four ways:

- with the memory word;
- with the memory word plus the set of other sharers to invalidate;
- with the identity of the node holding a modified copy;
- by sending a fetch-and-invalidate to that node and relaying its data once it arrives.

While a forwarded transaction on a block is open, the block is marked busy. Further requests to that block are refused with a negative acknowledgement, so the requester retries later. The message that closes the transaction is a revision (after a read) or a fetch reply (after a write). Closing messages that match no open transaction are discarded.

Messages enter over a valid/ready port and leave from a single registered valid/ready port. No new message is taken while a reply waits to leave.

Top module: `dir_home`

## Requirements
- R1: After reset every entry has no presence bits and a clear dirty flag, no block is busy, and the home word of block b is 16'hA500 XOR b. After reset out_valid is 0 and in_ready is 1.
- R2: An entry whose dirty flag is set always has exactly one presence bit set.
- R3: A read miss (in_type 0) from node i to a block that is neither busy nor dirty is answered with out_type 0 (data) to node i, carrying the home word. Presence bit i is then set.
- R4: A read miss to a dirty, non-busy block is answered with out_type 1 to the requester. out_data holds the owner's node index, zero-extended, and the block becomes busy on a pending read.
- R5: A revision (in_type 2) from the owner of a block busy on a pending read:
  - stores in_data as the home word;
  - clears dirty;
  - adds the original requester's presence bit and keeps the owner's;
  - ends the busy state;
  - sends no reply.
- R6: A write miss (in_type 1) from node i to a block that is neither busy nor dirty is answered with out_type 2 to node i. The reply carries the home word, and out_vec holds the old presence vector with bit i cleared. The entry then becomes presence bit i only, with dirty set.
- R7: A write miss to a dirty, non-busy block sends out_type 3 (fetch-and-invalidate) to the owner with out_data and out_vec zero. The block becomes busy on a pending write.
- R8: A fetch reply (in_type 3) from the owner of a block busy on a pending write:
  - sends out_type 0 to the original requester, carrying in_data;
  - stores in_data as the home word;
  - sets the entry to the requester's bit only, with dirty set;
  - ends the busy state.
- R9: A read or write miss to a busy block is answered with out_type 4 (negative acknowledgement) to the sender, with out_data and out_vec zero, and leaves the entry unchanged.
- R10: A revision or fetch reply that does not match an open transaction of its own kind is dropped with no reply and no change. This covers a non-busy block, the wrong pending kind, or a sender that is not the owner.
- R11: While out_valid is 1 and out_ready is 0, every output field holds steady and in_ready stays 0.
- R12: Every reply carries the block index of the message that caused it on out_blk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Directory can take a message |
| in_type | input | 2 | 0 read miss, 1 write miss, 2 revision, 3 fetch reply |
| in_src | input | 2 | Sending node |
| in_blk | input | 4 | Block index |
| in_data | input | 16 | Data word (revision and fetch reply) |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network can take the outgoing message |
| out_type | output | 3 | 0 data, 1 owner id, 2 data plus sharers, 3 fetch-and-invalidate, 4 nack |
| out_dst | output | 2 | Destination node |
| out_blk | output | 4 | Block index |
| out_data | output | 16 | Data word or owner index |
| out_vec | output | 4 | Sharers to invalidate |

## Verification
A corrupted presence vector shows at the next write miss to that block, as a wrong out_vec, one cycle after acceptance. A lost or wrong dirty flag shows at the next request to the block, as a data reply where an owner or fetch reply was due, or the reverse. A busy flag that is stuck or never set shows as a stray nack, or as a missing nack on the very next request. Interleaved random traffic over a few blocks reaches every rule, and the bench model checks each reply field by field.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        REQ_RD   = 2'd0,
        REQ_WR   = 2'd1,
        MSG_REV  = 2'd2,
        MSG_FREP = 2'd3
    } in_kind_e;

    typedef enum logic [2:0] {
        RSP_DATA     = 3'd0,
        RSP_OWNER    = 3'd1,
        RSP_DATAVEC  = 3'd2,
        FWD_FETCHINV = 3'd3,
        RSP_NACK     = 3'd4
    } out_kind_e;

    typedef enum logic {
        PEND_RD = 1'b0,
        PEND_WR = 1'b1
    } pend_kind_e;

    // index of the lowest set bit, 0 when none
    function automatic int unsigned first_set(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int k = 31; k >= 0; k--) begin
            if (v[k]) r = k;
        end
        return r;
    endfunction

    // home word loaded into block idx at reset
    function automatic logic [63:0] init_word(input int unsigned idx);
        return 64'hA500 ^ 64'(idx);
    endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 16,
    localparam int BLK_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  idx,
    output logic [NODES-1:0]  rd_pres,
    output logic              rd_dirty,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ent_we,
    input  logic [NODES-1:0]  wr_pres,
    input  logic              wr_dirty,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wdata
);

    logic [NODES-1:0]  pres_q  [BLOCKS];
    logic [BLOCKS-1:0] dirty_q;
    logic [DATA_W-1:0] mem_q   [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                pres_q[b]  <= '0;
                dirty_q[b] <= 1'b0;
                mem_q[b]   <= DATA_W'(init_word(b));
            end else if (idx == BLK_W'(b)) begin
                if (ent_we) begin
                    pres_q[b]  <= wr_pres;
                    dirty_q[b] <= wr_dirty;
                end
                if (mem_we) begin
                    mem_q[b] <= mem_wdata;
                end
            end
        end

        // R2: a modified block has a single holder
        p_dirty_onehot_r2: assert property (@(posedge clk) disable iff (rst)
            dirty_q[b] |-> ($countones(pres_q[b]) == 1));
    end

    assign rd_pres  = pres_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_data  = mem_q[idx];

endmodule

// File: rtl/dir_busy.sv
module dir_busy
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    localparam int BLK_W  = $clog2(BLOCKS),
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  idx,
    output logic              lk_busy,
    output pend_kind_e        lk_kind,
    output logic [NODE_W-1:0] lk_req,
    input  logic              set_en,
    input  pend_kind_e        set_kind,
    input  logic [NODE_W-1:0] set_req,
    input  logic              clr_en
);

    logic [BLOCKS-1:0] busy_q;
    logic [BLOCKS-1:0] kind_wr_q;
    logic [NODE_W-1:0] req_q [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                busy_q[b]    <= 1'b0;
                kind_wr_q[b] <= 1'b0;
                req_q[b]     <= '0;
            end else if (idx == BLK_W'(b)) begin
                if (set_en) begin
                    busy_q[b]    <= 1'b1;
                    kind_wr_q[b] <= (set_kind == PEND_WR);
                    req_q[b]     <= set_req;
                end else if (clr_en) begin
                    busy_q[b] <= 1'b0;
                end
            end
        end
    end

    assign lk_busy = busy_q[idx];
    assign lk_kind = kind_wr_q[idx] ? PEND_WR : PEND_RD;
    assign lk_req  = req_q[idx];

    // R9: a transaction is only opened on a free block
    p_open_free_r9: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !busy_q[idx]);

    // R10: only an open transaction is ever closed
    p_close_open_r10: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> busy_q[idx]);

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 16,
    localparam int BLK_W  = $clog2(BLOCKS),
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_type,
    input  logic [NODE_W-1:0] in_src,
    input  logic [BLK_W-1:0]  in_blk,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_type,
    output logic [NODE_W-1:0] out_dst,
    output logic [BLK_W-1:0]  out_blk,
    output logic [DATA_W-1:0] out_data,
    output logic [NODES-1:0]  out_vec,
    input  logic [NODES-1:0]  lk_pres,
    input  logic              lk_dirty,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              lk_busy,
    input  pend_kind_e        lk_kind,
    input  logic [NODE_W-1:0] lk_req,
    output logic              ent_we,
    output logic [NODES-1:0]  wr_pres,
    output logic              wr_dirty,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              set_en,
    output pend_kind_e        set_kind,
    output logic              clr_en
);

    localparam logic [NODES-1:0] ONE = NODES'(1);

    typedef struct packed {
        out_kind_e         kind;
        logic [NODE_W-1:0] dst;
        logic [BLK_W-1:0]  blk;
        logic [DATA_W-1:0] data;
        logic [NODES-1:0]  vec;
    } rsp_t;

    typedef enum logic {S_IDLE, S_SEND} state_e;

    state_e            state_q;
    rsp_t              out_q;
    rsp_t              rsp_d;
    logic              rsp_en;
    logic              accept;
    in_kind_e          in_kind;
    logic [NODES-1:0]  req_bit;
    logic [NODES-1:0]  pend_bit;
    logic [NODE_W-1:0] owner;
    logic              from_owner;

    assign in_ready   = (state_q == S_IDLE);
    assign accept     = in_valid && in_ready;
    assign in_kind    = in_kind_e'(in_type);
    assign req_bit    = ONE << in_src;
    assign pend_bit   = ONE << lk_req;
    assign owner      = NODE_W'(first_set(32'(lk_pres)));
    assign from_owner = (in_src == owner);

    always_comb begin
        rsp_en    = 1'b0;
        rsp_d     = '0;
        rsp_d.kind = RSP_NACK;
        rsp_d.dst = in_src;
        rsp_d.blk = in_blk;
        ent_we    = 1'b0;
        wr_pres   = lk_pres;
        wr_dirty  = lk_dirty;
        mem_we    = 1'b0;
        mem_wdata = in_data;
        set_en    = 1'b0;
        set_kind  = PEND_RD;
        clr_en    = 1'b0;
        if (accept) begin
            unique case (in_kind)
                REQ_RD: begin
                    rsp_en = 1'b1;
                    if (lk_busy) begin
                        rsp_d.kind = RSP_NACK;
                    end else if (lk_dirty) begin
                        rsp_d.kind = RSP_OWNER;
                        rsp_d.data = DATA_W'(owner);
                        set_en     = 1'b1;
                        set_kind   = PEND_RD;
                    end else begin
                        rsp_d.kind = RSP_DATA;
                        rsp_d.data = lk_data;
                        ent_we     = 1'b1;
                        wr_pres    = lk_pres | req_bit;
                        wr_dirty   = 1'b0;
                    end
                end
                REQ_WR: begin
                    rsp_en = 1'b1;
                    if (lk_busy) begin
                        rsp_d.kind = RSP_NACK;
                    end else if (lk_dirty) begin
                        rsp_d.kind = FWD_FETCHINV;
                        rsp_d.dst  = owner;
                        set_en     = 1'b1;
                        set_kind   = PEND_WR;
                    end else begin
                        rsp_d.kind = RSP_DATAVEC;
                        rsp_d.data = lk_data;
                        rsp_d.vec  = lk_pres & ~req_bit;
                        ent_we     = 1'b1;
                        wr_pres    = req_bit;
                        wr_dirty   = 1'b1;
                    end
                end
                MSG_REV: begin
                    if (lk_busy && lk_kind == PEND_RD && from_owner) begin
                        mem_we   = 1'b1;
                        ent_we   = 1'b1;
                        wr_pres  = lk_pres | pend_bit;
                        wr_dirty = 1'b0;
                        clr_en   = 1'b1;
                    end
                end
                MSG_FREP: begin
                    if (lk_busy && lk_kind == PEND_WR && from_owner) begin
                        rsp_en     = 1'b1;
                        rsp_d.kind = RSP_DATA;
                        rsp_d.dst  = lk_req;
                        rsp_d.data = in_data;
                        mem_we     = 1'b1;
                        ent_we     = 1'b1;
                        wr_pres    = pend_bit;
                        wr_dirty   = 1'b1;
                        clr_en     = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            out_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (rsp_en) begin
                    state_q <= S_SEND;
                    out_q   <= rsp_d;
                end
                S_SEND: if (out_ready) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign out_valid = (state_q == S_SEND);
    assign out_type  = out_q.kind;
    assign out_dst   = out_q.dst;
    assign out_blk   = out_q.blk;
    assign out_data  = out_q.data;
    assign out_vec   = out_q.vec;

    // R11: a stalled reply keeps every field
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_q)));

    // R9: requests to a busy block are refused
    p_nack_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && (in_kind == REQ_RD || in_kind == REQ_WR) && lk_busy)
        |=> (out_valid && out_q.kind == RSP_NACK));

    // R3: a clean read returns the stored word
    p_clean_read_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && in_kind == REQ_RD && !lk_busy && !lk_dirty)
        |=> (out_q.kind == RSP_DATA && out_q.data == $past(lk_data)));

    // R5: a revision never produces a reply
    p_rev_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && in_kind == MSG_REV) |=> !out_valid);

endmodule

// File: rtl/dir_home.sv
module dir_home
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 16,
    localparam int BLK_W  = $clog2(BLOCKS),
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_type,
    input  logic [NODE_W-1:0] in_src,
    input  logic [BLK_W-1:0]  in_blk,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_type,
    output logic [NODE_W-1:0] out_dst,
    output logic [BLK_W-1:0]  out_blk,
    output logic [DATA_W-1:0] out_data,
    output logic [NODES-1:0]  out_vec
);

    logic [NODES-1:0]  lk_pres;
    logic              lk_dirty;
    logic [DATA_W-1:0] lk_data;
    logic              lk_busy;
    pend_kind_e        lk_kind;
    logic [NODE_W-1:0] lk_req;
    logic              ent_we;
    logic [NODES-1:0]  wr_pres;
    logic              wr_dirty;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic              set_en;
    pend_kind_e        set_kind;
    logic              clr_en;

    dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .idx       (in_blk),
        .rd_pres   (lk_pres),
        .rd_dirty  (lk_dirty),
        .rd_data   (lk_data),
        .ent_we    (ent_we),
        .wr_pres   (wr_pres),
        .wr_dirty  (wr_dirty),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    dir_busy #(.NODES(NODES), .BLOCKS(BLOCKS)) u_busy (
        .clk      (clk),
        .rst      (rst),
        .idx      (in_blk),
        .lk_busy  (lk_busy),
        .lk_kind  (lk_kind),
        .lk_req   (lk_req),
        .set_en   (set_en),
        .set_kind (set_kind),
        .set_req  (in_src),
        .clr_en   (clr_en)
    );

    dir_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_type   (in_type),
        .in_src    (in_src),
        .in_blk    (in_blk),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_type  (out_type),
        .out_dst   (out_dst),
        .out_blk   (out_blk),
        .out_data  (out_data),
        .out_vec   (out_vec),
        .lk_pres   (lk_pres),
        .lk_dirty  (lk_dirty),
        .lk_data   (lk_data),
        .lk_busy   (lk_busy),
        .lk_kind   (lk_kind),
        .lk_req    (lk_req),
        .ent_we    (ent_we),
        .wr_pres   (wr_pres),
        .wr_dirty  (wr_dirty),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .set_en    (set_en),
        .set_kind  (set_kind),
        .clr_en    (clr_en)
    );

endmodule

// File: tb/tb_dir_home.sv
`timescale 1ns/1ps
module tb_dir_home;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_type = '0;
    logic [1:0]  in_src = '0;
    logic [3:0]  in_blk = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_type;
    logic [1:0]  out_dst;
    logic [3:0]  out_blk;
    logic [15:0] out_data;
    logic [3:0]  out_vec;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dir_home dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
        .in_src(in_src), .in_blk(in_blk), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
        .out_dst(out_dst), .out_blk(out_blk), .out_data(out_data), .out_vec(out_vec)
    );

    // reference state
    logic [3:0]  m_pres [16];
    bit          m_dirty[16];
    logic [15:0] m_mem  [16];
    bit          m_busy [16];
    bit          m_kwr  [16];
    logic [1:0]  m_req  [16];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] own_of(input logic [3:0] p);
        for (int k = 3; k >= 0; k--) begin
            if (p[k]) own_of = 2'(k);
        end
        if (p == 4'b0) own_of = 2'd0;
    endfunction

    task automatic model(input logic [1:0] t, input logic [1:0] s, input logic [3:0] b,
                         input logic [15:0] d, output bit resp, output logic [2:0] et,
                         output logic [1:0] ed, output logic [15:0] edat,
                         output logic [3:0] evec, output string tag);
        logic [3:0] me;
        logic [1:0] o;
        me = 4'b1 << s;
        o = own_of(m_pres[b]);
        resp = 0; et = 3'd4; ed = s; edat = '0; evec = '0; tag = "R10";
        case (t)
            2'd0: begin
                resp = 1;
                if (m_busy[b]) tag = "R9";
                else if (m_dirty[b]) begin
                    et = 3'd1; edat = 16'(o); tag = "R4";
                    m_busy[b] = 1; m_kwr[b] = 0; m_req[b] = s;
                end else begin
                    et = 3'd0; edat = m_mem[b]; tag = "R3";
                    m_pres[b] |= me;
                end
            end
            2'd1: begin
                resp = 1;
                if (m_busy[b]) tag = "R9";
                else if (m_dirty[b]) begin
                    et = 3'd3; ed = o; tag = "R7";
                    m_busy[b] = 1; m_kwr[b] = 1; m_req[b] = s;
                end else begin
                    et = 3'd2; edat = m_mem[b]; evec = m_pres[b] & ~me; tag = "R6";
                    m_pres[b] = me; m_dirty[b] = 1;
                end
            end
            2'd2: begin
                if (m_busy[b] && !m_kwr[b] && s == o) begin
                    m_mem[b] = d; m_dirty[b] = 0;
                    m_pres[b] |= 4'b1 << m_req[b]; m_busy[b] = 0; tag = "R5";
                end
            end
            default: begin
                if (m_busy[b] && m_kwr[b] && s == o) begin
                    resp = 1; et = 3'd0; ed = m_req[b]; edat = d; tag = "R8";
                    m_mem[b] = d; m_pres[b] = 4'b1 << m_req[b]; m_dirty[b] = 1;
                    m_busy[b] = 0;
                end
            end
        endcase
    endtask

    // sends one message at a negedge and checks the outcome
    task automatic step(input logic [1:0] t, input logic [1:0] s, input logic [3:0] b,
                        input logic [15:0] d, input int hold);
        bit resp; logic [2:0] et; logic [1:0] ed; logic [15:0] edat; logic [3:0] evec;
        string tag;
        logic [2:0] st; logic [1:0] sd; logic [3:0] sb; logic [15:0] sdat; logic [3:0] sv;
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_type = t; in_src = s; in_blk = b; in_data = d;
        model(t, s, b, d, resp, et, ed, edat, evec, tag);
        @(negedge clk);
        in_valid = 0;
        if (resp) begin
            chk(out_valid === 1'b1, tag, "reply present", 32'(out_valid), 1);
            st = out_type; sd = out_dst; sb = out_blk; sdat = out_data; sv = out_vec;
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk(out_valid === 1'b1 && in_ready === 1'b0 && out_type === st &&
                    out_dst === sd && out_blk === sb && out_data === sdat && out_vec === sv,
                    "R11", "stall hold", {out_valid, in_ready, out_type, out_data},
                    {1'b1, 1'b0, st, sdat});
            end
            chk(out_type === et, tag, "out_type", 32'(out_type), 32'(et));
            chk(out_dst === ed, tag, "out_dst", 32'(out_dst), 32'(ed));
            chk(out_blk === b, "R12", "out_blk", 32'(out_blk), 32'(b));
            chk(out_data === edat, tag, "out_data", 32'(out_data), 32'(edat));
            chk(out_vec === evec, tag, "out_vec", 32'(out_vec), 32'(evec));
            out_ready = 1;
            @(negedge clk);
            out_ready = 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                chk(out_valid === 1'b0, tag, "no reply", 32'(out_valid), 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 16; b++) begin
            m_pres[b] = '0; m_dirty[b] = 0; m_mem[b] = 16'hA500 ^ 16'(b);
            m_busy[b] = 0; m_kwr[b] = 0; m_req[b] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle port state after reset
        chk(out_valid === 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
        chk(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
        // R1 reset words seen through clean reads
        step(2'd0, 2'd2, 4'd0, 16'h0, 0);
        step(2'd0, 2'd1, 4'd15, 16'h0, 1);
        // sharers then a clean write: vector excludes the writer (R6)
        step(2'd0, 2'd0, 4'd5, 16'h0, 0);
        step(2'd0, 2'd1, 4'd5, 16'h0, 0);
        step(2'd0, 2'd3, 4'd5, 16'h0, 0);
        step(2'd1, 2'd3, 4'd5, 16'h0, 2);
        // dirty write goes through a fetch (R7), conflicts are refused (R9)
        step(2'd1, 2'd1, 4'd5, 16'h0, 0);
        step(2'd0, 2'd0, 4'd5, 16'h0, 0);
        step(2'd1, 2'd2, 4'd5, 16'h0, 0);
        // stray closures are dropped (R10)
        step(2'd2, 2'd3, 4'd5, 16'h1111, 0);
        step(2'd3, 2'd2, 4'd5, 16'h2222, 0);
        step(2'd3, 2'd0, 4'd9, 16'h3333, 0);
        // proper fetch reply relayed (R8)
        step(2'd3, 2'd3, 4'd5, 16'h1234, 0);
        // dirty read returns owner id (R4), then revision (R5)
        step(2'd0, 2'd2, 4'd5, 16'h0, 1);
        step(2'd3, 2'd1, 4'd5, 16'h4444, 0);
        step(2'd2, 2'd1, 4'd5, 16'h5678, 0);
        step(2'd0, 2'd0, 4'd5, 16'h0, 0);
        step(2'd1, 2'd2, 4'd5, 16'h0, 0);
        // writer that already owns a dirty block
        step(2'd1, 2'd2, 4'd5, 16'h0, 0);
        step(2'd3, 2'd2, 4'd5, 16'h9abc, 0);
        // random mix over a few hot blocks
        for (int it = 0; it < 600; it++) begin
            logic [3:0] b;
            logic [1:0] t;
            logic [1:0] s;
            b = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 3);
            if (m_busy[b] && ($urandom % 2 == 0)) begin
                t = m_kwr[b] ? 2'd3 : 2'd2;
                s = own_of(m_pres[b]);
            end else begin
                t = 2'($urandom);
                s = 2'($urandom);
            end
            step(t, s, b, 16'($urandom), int'($urandom % 3));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule